// File: doc/BRIEF.md
# Timer with Edge-Selected Input Capture

This block is a 16-bit up-counting timer with a selectable prescaler and one input capture channel. An external capture pin is brought into the clock domain through a synchronizer. When the chosen transition appears on it, the running count is stored in a 16-bit capture register and a capture flag is set. Software can use this to timestamp external events, such as measuring a period or a pulse width in timer ticks.

The timer counts up to a TOP value and then wraps to zero, setting an overflow flag. TOP is all ones in normal mode. A mode bit makes the capture register serve as TOP instead. While that bit is set, the capture register belongs to software, and pin edges are ignored.

All state is reached over an 8-bit register bus:

| Address | Register |
|---|---|
| 0 | control |
| 1 | counter low byte |
| 2 | counter high byte |
| 3 | capture low byte |
| 4 | capture high byte |
| 5 | flags |
| 6 | interrupt enables |

Reading a low byte latches the matching high byte, so a 16-bit value can be read atomically. Two level interrupt outputs are provided, one for capture and one for overflow.

Top module: `cap_timer16`

## Requirements
- R1: Control bit 3 selects the capture edge. When it is 1, a rising pin transition captures. When it is 0 (the reset value), a falling transition captures, and the opposite transition has no effect on the capture register or the capture flag.
- R2: On a qualifying edge, the capture register takes the counter value and flags bit 1 (capture) is set. The write from this event wins over a software write to the capture register in the same cycle.
- R3: While control bit 4 (capture register is TOP) is 1, pin edges neither change the capture register nor set the capture flag.
- R4: A 16-bit write goes through a write-holding byte. Writing address 2 or 4 stores the high byte there. Writing address 1 or 3 then loads both bytes at once. A read of address 1 or 3 latches the current high byte, and a following read of address 2 or 4 returns that latched byte.
- R5: Control bits [2:0] select the count rate: 0 stops the counter, 1 counts every clock, and 2, 3, 4 and 5 count once per 8, 64, 256 and 1024 clocks. The divider restarts when the field is written with a different code. A read of the counter n clocks after such a write returns floor((n-1)/D), where D is the division ratio.
- R6: When the counter is at TOP and a count tick arrives, it goes to 0 and flags bit 0 (overflow) is set. TOP is 0xFFFF in normal mode and the capture register when control bit 4 is 1.
- R7: The overflow interrupt output equals flags bit 0 AND enables bit 0. The capture interrupt output equals flags bit 1 AND enables bit 1.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a capture event and a clear of the capture flag land in the same cycle, the flag stays set.
- R9: The pin passes through a two-stage synchronizer. One pin transition produces at most one capture, and the capture lands on the third rising clock edge after the pin changes.
- R10: After reset, every register reads 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_pin | input | 1 | External capture pin, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next clock edge |
| bus_rdata | output | 8 | Registered read data |
| irq_cap | output | 1 | Capture interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The rate selection is swept over every nonzero code. Each code is read at 1, D, D+1 and 3D+5 clocks after the divider restarts, which separates a wrong ratio, a divider that does not restart, and an off-by-one tick phase. Captures are tried for both edge settings over count values that include all zeros, all ones, a single high bit and byte-boundary patterns. Each qualifying transition is followed by the opposite transition, which must leave the register and flag unchanged, so a swapped or ignored edge select shows up. Wrap behaviour is checked just before and after 0xFFFF and with a small TOP taken from the capture register, while pin edges are applied to show they are ignored in that mode. A low-byte read that straddles a carry separates a latched high-byte read from a live one, and a clear issued in the capture cycle shows which side has priority.

// File: rtl/cap_timer_pkg.sv
`timescale 1ns/1ps
package cap_timer_pkg;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
   localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
   localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd3;
   localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd4;
   localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;
   localparam logic [ADDR_W-1:0] A_MASK   = 3'd6;

   localparam int FLAG_OVF = 0;
   localparam int FLAG_CAP = 1;
   localparam int NUM_FLAGS = 2;

   localparam int CS_W     = 3;
   localparam int CTRL_W   = 5;
   localparam int NUM_DIV  = 4;   // divided rates, codes 2 .. 2+NUM_DIV-1

   // log2 of the division ratio for divided rate i
   function automatic int div_shift(input int i);
      case (i)
         0:       return 3;
         1:       return 6;
         2:       return 8;
         default: return 10;
      endcase
   endfunction

   typedef struct packed {
      logic            top_cap;   // bit 4: capture register acts as TOP
      logic            edge_rise; // bit 3: 1 = rising edge captures
      logic [CS_W-1:0] cs;        // bits 2:0: rate select
   } ctrl_t;

endpackage

// File: rtl/capt_pin_sync.sv
`timescale 1ns/1ps
module capt_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic hit
);

   if (STAGES < 2) begin : g_bad_stages
      $error("capt_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              lvl;
   logic              rise;
   logic              fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_LVL}};
         prev_q  <= RST_LVL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl  = chain_q[STAGES-1];
   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
   assign hit  = rise_sel ? rise : fall;

   // R9: a rising detection cannot repeat on the next cycle
   p_single_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl && !prev_q) |=> !(lvl && !prev_q));
   // R9: a falling detection cannot repeat on the next cycle
   p_single_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl && prev_q) |=> !(!lvl && prev_q));

endmodule

// File: rtl/capt_prescaler.sv
`timescale 1ns/1ps
module capt_prescaler
   import cap_timer_pkg::*;
#(
   parameter int DIV_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CS_W-1:0] cs,
   input  logic            restart,
   output logic            tick
);

   if (DIV_W < div_shift(NUM_DIV-1)) begin : g_bad_div
      $error("capt_prescaler: DIV_W too small for the largest ratio");
   end

   logic [DIV_W-1:0]   div_q;
   logic [NUM_DIV-1:0] tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (restart) div_q <= '0;
      else              div_q <= div_q + DIV_W'(1);
   end

   for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
      localparam int SH = div_shift(i);
      assign tap[i] = &div_q[SH-1:0];
   end

   always_comb begin
      tick = 1'b0;
      if (cs == CS_W'(1)) tick = 1'b1;
      for (int i = 0; i < NUM_DIV; i++) begin
         if (cs == CS_W'(i + 2)) tick = tap[i];
      end
   end

   // R5: divided rates never tick on two adjacent cycles
   p_div_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cs >= CS_W'(2) && !restart) |=> !tick);
   // R5: after a restart the first divided tick is not immediate
   p_restart_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && cs >= CS_W'(1)) |=> !(tick && cs >= CS_W'(2)));

endmodule

// File: rtl/capt_counter.sv
`timescale 1ns/1ps
module capt_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] top,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   if (W < 2) begin : g_bad_w
      $error("capt_counter: W must be at least 2");
   end

   assign wrap = tick && !load && (cnt == top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (tick)  cnt <= (cnt == top) ? '0 : cnt + W'(1);
   end

   // R6: a wrap leaves the counter at zero
   p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
   // R5: without a tick or load the counter holds
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/cap_timer16.sv
`timescale 1ns/1ps
module cap_timer16
   import cap_timer_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_W       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_pin,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_cap,
   output logic              irq_ovf
);

   localparam int CNT_W = 2 * DATA_W;

   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("cap_timer16: DATA_W must hold the control fields");
   end

   ctrl_t                ctrl_q;
   logic [NUM_FLAGS-1:0] flag_q;
   logic [NUM_FLAGS-1:0] mask_q;
   logic [CNT_W-1:0]     cap_q;
   logic [CNT_W-1:0]     cnt;
   logic [DATA_W-1:0]    wr_hold_q;
   logic [DATA_W-1:0]    rd_hold_q;

   logic wr_ctrl, wr_cnt_lo, wr_cap_lo, wr_hi, wr_flags, wr_mask;
   logic restart, tick, cnt_wrap, pin_hit, cap_evt;
   logic [CNT_W-1:0] top_val;
   logic [NUM_FLAGS-1:0] flag_set;

   // ---------------- write decode ----------------
   assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
   assign wr_cnt_lo = bus_wr && (bus_addr == A_CNT_LO);
   assign wr_cap_lo = bus_wr && (bus_addr == A_CAP_LO);
   assign wr_hi     = bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CAP_HI);
   assign wr_flags  = bus_wr && (bus_addr == A_FLAGS);
   assign wr_mask   = bus_wr && (bus_addr == A_MASK);

   assign restart = wr_ctrl && (bus_wdata[CS_W-1:0] != ctrl_q.cs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         mask_q    <= '0;
         wr_hold_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q    <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (wr_mask) mask_q    <= bus_wdata[NUM_FLAGS-1:0];
         if (wr_hi)   wr_hold_q <= bus_wdata;
      end
   end

   // ---------------- rate and counter ----------------
   capt_prescaler #(.DIV_W(DIV_W)) i_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (ctrl_q.cs),
      .restart (restart),
      .tick    (tick)
   );

   assign top_val = ctrl_q.top_cap ? cap_q : '1;

   capt_counter #(.W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .top      (top_val),
      .load     (wr_cnt_lo),
      .load_val ({wr_hold_q, bus_wdata}),
      .cnt      (cnt),
      .wrap     (cnt_wrap)
   );

   // ---------------- capture path ----------------
   capt_pin_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b0)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (cap_pin),
      .rise_sel (ctrl_q.edge_rise),
      .hit      (pin_hit)
   );

   assign cap_evt = pin_hit && !ctrl_q.top_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cap_q <= '0;
      else if (cap_evt)   cap_q <= cnt;
      else if (wr_cap_lo) cap_q <= {wr_hold_q, bus_wdata};
   end

   // ---------------- flags and interrupts ----------------
   always_comb begin
      flag_set           = '0;
      flag_set[FLAG_OVF] = cnt_wrap;
      flag_set[FLAG_CAP] = cap_evt;
   end

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       flag_q[f] <= 1'b0;
         else if (flag_set[f])             flag_q[f] <= 1'b1;
         else if (wr_flags && bus_wdata[f]) flag_q[f] <= 1'b0;
      end
   end

   assign irq_ovf = flag_q[FLAG_OVF] & mask_q[FLAG_OVF];
   assign irq_cap = flag_q[FLAG_CAP] & mask_q[FLAG_CAP];

   // ---------------- read path ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         rd_hold_q <= '0;
      end else if (bus_rd) begin
         case (bus_addr)
            A_CTRL:   bus_rdata <= DATA_W'(ctrl_q);
            A_CNT_LO: begin
               bus_rdata <= cnt[DATA_W-1:0];
               rd_hold_q <= cnt[CNT_W-1:DATA_W];
            end
            A_CAP_LO: begin
               bus_rdata <= cap_q[DATA_W-1:0];
               rd_hold_q <= cap_q[CNT_W-1:DATA_W];
            end
            A_CNT_HI, A_CAP_HI: bus_rdata <= rd_hold_q;
            A_FLAGS:  bus_rdata <= DATA_W'(flag_q);
            A_MASK:   bus_rdata <= DATA_W'(mask_q);
            default:  bus_rdata <= '0;
         endcase
      end
   end

   // R2: a capture stores the count seen in the event cycle and sets the flag
   p_capture_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cap_q == $past(cnt) && flag_q[FLAG_CAP]));
   // R3: in capture-as-TOP mode only software changes the capture register
   p_topcap_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.top_cap && !wr_cap_lo) |=> $stable(cap_q));
   // R6: a wrap always leaves the overflow flag set
   p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wrap |=> flag_q[FLAG_OVF]);
   // R4: a counter low-byte read latches the high byte of that cycle
   p_atomic_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_CNT_LO) |=> (rd_hold_q == $past(cnt[CNT_W-1:DATA_W])));
   // R8: a capture in the same cycle as a clear keeps the flag set
   p_capture_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && wr_flags && bus_wdata[FLAG_CAP]) |=> flag_q[FLAG_CAP]);

endmodule

// File: tb/test_cap_timer16.sv
`timescale 1ns/1ps
module test_cap_timer16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cap_pin;
   logic [2:0] bus_addr;
   logic [7:0] bus_wdata;
   logic       bus_wr;
   logic       bus_rd;
   logic [7:0] bus_rdata;
   logic       irq_cap;
   logic       irq_ovf;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   cap_timer16 i_cap_timer16 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_pin   (cap_pin),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .irq_cap   (irq_cap),
      .irq_ovf   (irq_ovf)
   );

   localparam logic [2:0] CTRL = 3'd0, CNTL = 3'd1, CNTH = 3'd2,
                          CAPL = 3'd3, CAPH = 3'd4, FLG = 3'd5, MSK = 3'd6;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
      logic [7:0] l, h;
      rd(lo, l);
      rd(lo + 3'd1, h);
      v = {h, l};
   endtask

   task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
      wr(lo + 3'd1, v[15:8]);
      wr(lo, v[7:0]);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] v, v0;
      logic [15:0] vals [6];
      vals = '{16'h0000, 16'hFFFF, 16'h00FF, 16'h1234, 16'h8000, 16'hA5C3};

      rst_n = 1'b0; cap_pin = 1'b0; bus_addr = '0; bus_wdata = '0;
      bus_wr = 1'b0; bus_rd = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R10: reset state
      chk("R10", "irq_cap", int'(irq_cap), 0);
      chk("R10", "irq_ovf", int'(irq_ovf), 0);
      for (int a = 0; a < 7; a++) begin
         rd(3'(a), b);
         chk("R10", $sformatf("reg %0d", a), int'(b), 0);
      end

      // R4: write order high then low commits both bytes
      wr16(CNTL, 16'hABCD);
      rd16(CNTL, v);
      chk("R4", "counter write", int'(v), 16'hABCD);
      wr16(CAPL, 16'h3C96);
      rd16(CAPL, v);
      chk("R4", "capture write", int'(v), 16'h3C96);

      // R5: rate sweep over every nonzero code
      for (int c = 1; c <= 5; c++) begin
         int d;
         int ns [4];
         d = (c == 1) ? 1 : (1 << ((c == 2) ? 3 : (c == 3) ? 6 : (c == 4) ? 8 : 10));
         ns = '{1, d, d + 1, 3 * d + 5};
         for (int k = 0; k < 4; k++) begin
            wr(CTRL, 8'h00);
            wr16(CNTL, 16'h0000);
            wr(CTRL, 8'(c));
            idle(ns[k] - 1);
            rd16(CNTL, v);
            chk("R5", $sformatf("code %0d after %0d clocks", c, ns[k]), int'(v), (ns[k] - 1) / d);
         end
      end

      // R5: code 0 stops
      wr(CTRL, 8'h00);
      rd16(CNTL, v0);
      idle(20);
      rd16(CNTL, v);
      chk("R5", "stopped counter", int'(v), int'(v0));

      // R4: atomic read straddling a carry
      wr16(CNTL, 16'h00FE);
      wr(CTRL, 8'h01);
      rd(CNTL, b); chk("R4", "low before carry", int'(b), 8'hFE);
      rd(CNTH, b); chk("R4", "latched high", int'(b), 8'h00);
      rd(CNTL, b); chk("R4", "low after carry", int'(b), 8'h00);
      rd(CNTH, b); chk("R4", "high after carry", int'(b), 8'h01);
      wr(CTRL, 8'h00);

      // R6, R7, R8: overflow at 0xFFFF
      wr(FLG, 8'h03);
      wr(MSK, 8'h00);
      wr16(CNTL, 16'hFFFE);
      wr(CTRL, 8'h01);
      rd(FLG, b); chk("R6", "flags at FFFE", int'(b), 0);
      rd(FLG, b); chk("R6", "flags at FFFF", int'(b), 0);
      rd(FLG, b); chk("R6", "flags after wrap", int'(b), 1);
      chk("R7", "irq_ovf masked", int'(irq_ovf), 0);
      wr(MSK, 8'h01);
      chk("R7", "irq_ovf enabled", int'(irq_ovf), 1);
      chk("R7", "irq_cap idle", int'(irq_cap), 0);
      wr(FLG, 8'h00);
      rd(FLG, b); chk("R8", "write 0 keeps flag", int'(b), 1);
      wr(FLG, 8'h01);
      rd(FLG, b); chk("R8", "write 1 clears flag", int'(b), 0);
      chk("R7", "irq_ovf after clear", int'(irq_ovf), 0);
      wr(CTRL, 8'h00);
      wr(MSK, 8'h00);

      // R3, R6: capture register as TOP = 5
      wr(CTRL, 8'h10);
      wr16(CAPL, 16'h0005);
      wr16(CNTL, 16'h0000);
      wr(FLG, 8'h03);
      wr(CTRL, 8'h11);
      for (int n = 1; n <= 14; n++) begin
         rd(CNTL, b);
         chk("R6", $sformatf("TOP=5 read %0d", n), int'(b), (n - 1) % 6);
      end
      rd(FLG, b); chk("R6", "overflow at capture TOP", int'(b), 1);
      cap_pin = 1'b1; idle(4);
      cap_pin = 1'b0; idle(4);
      rd16(CAPL, v); chk("R3", "capture kept in TOP mode", int'(v), 5);
      rd(FLG, b); chk("R3", "no capture flag in TOP mode", int'(b & 8'h02), 0);
      wr(CTRL, 8'h00);
      wr(FLG, 8'h03);

      // R1, R2, R9: capture sweep over both edges
      for (int e = 0; e < 2; e++) begin
         logic p;
         p = (e == 0) ? 1'b1 : 1'b0;
         for (int k = 0; k < 6; k++) begin
            wr(CTRL, (e == 1) ? 8'h08 : 8'h00);
            cap_pin = p; idle(4);
            wr(FLG, 8'h03);
            wr16(CNTL, vals[k]);
            cap_pin = ~p; idle(4);
            rd16(CAPL, v);
            chk("R2", $sformatf("edge %0d value", e), int'(v), int'(vals[k]));
            rd(FLG, b); chk("R2", $sformatf("edge %0d flag", e), int'(b), 2);
            wr(FLG, 8'h02);
            wr16(CNTL, vals[k] ^ 16'h5A5A);
            idle(3);
            rd(FLG, b); chk("R9", "single capture per edge", int'(b), 0);
            cap_pin = p; idle(4);
            rd16(CAPL, v);
            chk("R1", $sformatf("edge %0d opposite ignored", e), int'(v), int'(vals[k]));
            rd(FLG, b); chk("R1", $sformatf("edge %0d opposite no flag", e), int'(b), 0);
         end
      end

      // R9, R8: capture lands on third edge, same cycle as a clear
      wr(CTRL, 8'h08);
      wr(FLG, 8'h03);
      wr16(CNTL, 16'h0777);
      cap_pin = 1'b1;
      idle(2);
      wr(FLG, 8'h02);
      rd(FLG, b); chk("R8", "capture beats clear", int'(b), 2);
      rd16(CAPL, v); chk("R9", "capture at third edge", int'(v), 16'h0777);

      // R7: capture interrupt
      wr(MSK, 8'h02);
      chk("R7", "irq_cap enabled", int'(irq_cap), 1);
      chk("R7", "irq_ovf off", int'(irq_ovf), 0);
      wr(MSK, 8'h00);
      chk("R7", "irq_cap masked", int'(irq_cap), 0);
      wr(FLG, 8'h02);
      rd(FLG, b); chk("R8", "capture flag cleared", int'(b), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule